// File: doc/BRIEF.md
# CAN Controller Power and Wake-Up Manager

This block sequences the low-power states of a CAN protocol controller. It runs in one of five modes: normal, sleep-pending, sleep, power-down and recovery. The host programs it through a small register port. The CPU tells it when the CPU stops or waits. The block watches the raw receive line and sits between the protocol engine's transmit bit and the transmit pin.

Power-down can be forced while a frame is in progress. When that happens the block signals an abort to the protocol engine and holds the transmit pin recessive. Once power returns, it runs a fixed recovery count before it reports that it is ready. If the controller was already asleep when power-down began, the recovery count is skipped.

In sleep, a dominant level on the receive line can wake the controller. An optional glitch filter first demands a run of consecutive dominant samples. A wake-up sets a sticky flag, which can raise an interrupt.

Top module: `can_pwr_mgr`

Register map (8-bit data, 2-bit address):
- Address 0, control (read/write): bit 0 is sleep request, bit 1 is wake enable, bit 2 is filter select, bit 3 is wait-disable and bit 4 is wake interrupt enable. The upper bits read as 0.
- Address 1, status: bit 0 is sleep acknowledge, bit 1 is the wake flag (cleared by writing 1 to it) and bit 2 is ready.
- Addresses 2 and 3 read as 0.

## Requirements
- R1: The power-down request is `cpu_stop`, or `cpu_wait` together with control bit 3. While the request is high, the block is in power-down on the next clock and `clk_en` is 0. `cpu_wait` with control bit 3 clear causes no power-down.
- R2: `abort` is 1 in the same cycle that a power-down request is present while the mode is normal or sleep-pending. `abort` is 0 when power-down is entered from sleep, and it is 0 once power-down is reached.
- R3: `tx_out` is 1 whenever a power-down request is present, and in the sleep, power-down and recovery modes. In normal mode, `tx_out` follows `tx_engine`.
- R4: In power-down, host writes have no effect and `host_rdata` reads 0.
- R5: A power-down entered from any mode other than sleep leads, once the request drops, to a recovery period of RECOV_CYC cycles. `ready` (status bit 2) stays 0 during this period and becomes 1 on the clock edge that follows it.
- R6: A power-down entered from sleep returns straight to sleep once the request drops. `sleep_ack` is 1 on the next clock, with no recovery period.
- R7: In sleep, with wake enable set and filter select clear, a 0 on `rx_in` moves the block to normal mode at the next clock. The same edge sets the wake flag and clears the sleep request bit.
- R8: With filter select set, a wake-up needs FILT_LEN consecutive clock samples of `rx_in` = 0. Any sample of 1 restarts the count, so shorter runs never wake the block.
- R9: The wake flag stays set until the host writes 1 to status bit 1. `wake_irq` equals the wake flag ANDed with control bit 4.
- R10: A sleep request is acknowledged only once `engine_idle` is 1. Until then `sleep_ack` stays 0.
- R11: With wake enable clear, receive-line activity in sleep causes no wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data (combinational) |
| cpu_stop | input | 1 | CPU is in stop mode |
| cpu_wait | input | 1 | CPU is in wait mode |
| rx_in | input | 1 | Raw receive line, 0 = dominant |
| engine_idle | input | 1 | Protocol engine reports no frame in progress |
| tx_engine | input | 1 | Transmit bit from the protocol engine |
| tx_out | output | 1 | Transmit line after the recessive override |
| abort | output | 1 | Abort strobe to the protocol engine |
| clk_en | output | 1 | Clock enable for the controller core, 0 in power-down |
| wake_irq | output | 1 | Wake-up interrupt |
| sleep_ack | output | 1 | Sleep mode acknowledged |
| ready | output | 1 | In normal mode |

## Verification
The bench attacks the glitch filter with random dominant runs that are one sample short of the threshold. A filter with an off-by-one error, or one that does not restart on a recessive sample, would wake on these runs. It counts the recovery period to the exact cycle, so a counter loaded with the wrong value would raise `ready` one cycle early or late. It separates a clean power-down from an unclean one: a design that always runs recovery would leave `sleep_ack` low after a clean wake, and one that never runs it would report `ready` at once. It also writes while in power-down and then checks that the control register is unchanged after power returns.

// File: rtl/can_pm_pkg.sv
package can_pm_pkg;

  typedef enum logic [2:0] {
    PM_NORMAL     = 3'd0,
    PM_SLEEP_PEND = 3'd1,
    PM_SLEEP      = 3'd2,
    PM_PDOWN      = 3'd3,
    PM_RECOVER    = 3'd4
  } pm_mode_e;

  localparam int CTL_SLEEP = 0;
  localparam int CTL_WAKE  = 1;
  localparam int CTL_FILT  = 2;
  localparam int CTL_WDIS  = 3;
  localparam int CTL_WIE   = 4;
  localparam int CTL_W     = 5;

  localparam int ST_ACK   = 0;
  localparam int ST_FLAG  = 1;
  localparam int ST_READY = 2;

  // Power-down request from the CPU low-power indications
  function automatic logic pd_request(logic stop, logic wt, logic wdis);
    return stop | (wt & wdis);
  endfunction

  // Modes in which a frame may be in progress on the bus
  function automatic logic traffic_live(pm_mode_e m);
    return (m == PM_NORMAL) || (m == PM_SLEEP_PEND);
  endfunction

endpackage

// File: rtl/can_pm_wake_det.sv
module can_pm_wake_det #(
  parameter int FILT_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic filt_en,
  input  logic rx_in,
  output logic wake
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic [CW-1:0] run_q;
  logic          dom;

  assign dom  = armed && !rx_in;
  assign wake = dom && (!filt_en || run_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_q <= '0;
    else if (!dom)           run_q <= '0;
    else if (run_q != LAST)  run_q <= run_q + 1'b1;
  end
endmodule

// File: rtl/can_pm_recov.sv
module can_pm_recov #(
  parameter int RECOV_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam int CW = (RECOV_CYC > 1) ? $clog2(RECOV_CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(RECOV_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign done = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (start)                cnt_q <= LOAD;
    else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/can_pm_regs.sv
module can_pm_regs
  import can_pm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [7:0]       wdata,
  input  logic             lock,
  input  logic             wake_evt,
  input  logic             sleep_ack,
  input  logic             ready,
  output logic [CTL_W-1:0] ctrl_q,
  output logic             wake_flag,
  output logic [7:0]       rdata
);
  logic wr_ctl, wr_st;

  assign wr_ctl = wr && !lock && addr == 2'd0;
  assign wr_st  = wr && !lock && addr == 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      wake_flag <= 1'b0;
    end else begin
      if (wr_ctl) ctrl_q <= wdata[CTL_W-1:0];
      if (wake_evt) ctrl_q[CTL_SLEEP] <= 1'b0;
      if (wake_evt)                        wake_flag <= 1'b1;
      else if (wr_st && wdata[ST_FLAG])    wake_flag <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (!lock) begin
      case (addr)
        2'd0: rdata[CTL_W-1:0] = ctrl_q;
        2'd1: begin
          rdata[ST_ACK]   = sleep_ack;
          rdata[ST_FLAG]  = wake_flag;
          rdata[ST_READY] = ready;
        end
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/can_pwr_mgr.sv
module can_pwr_mgr
  import can_pm_pkg::*;
#(
  parameter int RECOV_CYC = 16,
  parameter int FILT_LEN  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic [1:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       cpu_stop,
  input  logic       cpu_wait,
  input  logic       rx_in,
  input  logic       engine_idle,
  input  logic       tx_engine,
  output logic       tx_out,
  output logic       abort,
  output logic       clk_en,
  output logic       wake_irq,
  output logic       sleep_ack,
  output logic       ready
);
  pm_mode_e         mode, mode_nxt;
  logic [CTL_W-1:0] ctrl_q;
  logic             wake_flag;
  logic             pd_req;
  logic             clean_q;
  logic             wake_evt;
  logic             rec_start, rec_done;

  assign pd_req    = pd_request(cpu_stop, cpu_wait, ctrl_q[CTL_WDIS]);
  assign abort     = pd_req && traffic_live(mode);
  assign tx_out    = (pd_req || !traffic_live(mode)) ? 1'b1 : tx_engine;
  assign clk_en    = (mode != PM_PDOWN);
  assign sleep_ack = (mode == PM_SLEEP);
  assign ready     = (mode == PM_NORMAL);
  assign wake_irq  = wake_flag && ctrl_q[CTL_WIE];
  assign rec_start = (mode == PM_PDOWN) && !pd_req && !clean_q;

  can_pm_wake_det #(.FILT_LEN(FILT_LEN)) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .armed   ((mode == PM_SLEEP) && ctrl_q[CTL_WAKE] && !pd_req),
    .filt_en (ctrl_q[CTL_FILT]),
    .rx_in   (rx_in),
    .wake    (wake_evt)
  );

  can_pm_recov #(.RECOV_CYC(RECOV_CYC)) u_recov (
    .clk   (clk),
    .rst_n (rst_n),
    .start (rec_start),
    .run   (mode == PM_RECOVER),
    .done  (rec_done)
  );

  can_pm_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (host_wr),
    .addr      (host_addr),
    .wdata     (host_wdata),
    .lock      (mode == PM_PDOWN),
    .wake_evt  (wake_evt),
    .sleep_ack (sleep_ack),
    .ready     (ready),
    .ctrl_q    (ctrl_q),
    .wake_flag (wake_flag),
    .rdata     (host_rdata)
  );

  always_comb begin
    mode_nxt = mode;
    if (mode == PM_PDOWN) begin
      if (!pd_req) mode_nxt = clean_q ? PM_SLEEP : PM_RECOVER;
    end else if (pd_req) begin
      mode_nxt = PM_PDOWN;
    end else begin
      case (mode)
        PM_NORMAL:     if (ctrl_q[CTL_SLEEP]) mode_nxt = PM_SLEEP_PEND;
        PM_SLEEP_PEND: if (!ctrl_q[CTL_SLEEP]) mode_nxt = PM_NORMAL;
                       else if (engine_idle)   mode_nxt = PM_SLEEP;
        PM_SLEEP:      if (wake_evt || !ctrl_q[CTL_SLEEP]) mode_nxt = PM_NORMAL;
        PM_RECOVER:    if (rec_done) mode_nxt = PM_NORMAL;
        default:       mode_nxt = PM_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= PM_NORMAL;
      clean_q <= 1'b0;
    end else begin
      mode <= mode_nxt;
      if (mode != PM_PDOWN && pd_req) clean_q <= (mode == PM_SLEEP);
    end
  end
endmodule

// File: rtl/can_pm_checker.sv
module can_pm_checker
  import can_pm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input pm_mode_e         mode,
  input logic             pd_req,
  input logic             abort,
  input logic             tx_out,
  input logic [CTL_W-1:0] ctrl_q,
  input logic             wake_evt,
  input logic             wake_flag,
  input logic             ready,
  input logic             clean_q
);
  p_pd_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_req && mode != PM_PDOWN) |=> (mode == PM_PDOWN));

  p_abort_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (mode == PM_PDOWN));

  p_tx_recessive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_PDOWN) |-> tx_out);

  p_ctrl_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_PDOWN) |=> $stable(ctrl_q));

  p_recover_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_RECOVER) |-> !ready);

  p_clean_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_PDOWN && clean_q && !pd_req) |=> (mode == PM_SLEEP));

  p_wake_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> (wake_flag && !ctrl_q[CTL_SLEEP]));
endmodule

bind can_pwr_mgr can_pm_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .pd_req    (pd_req),
  .abort     (abort),
  .tx_out    (tx_out),
  .ctrl_q    (ctrl_q),
  .wake_evt  (wake_evt),
  .wake_flag (wake_flag),
  .ready     (ready),
  .clean_q   (clean_q)
);

// File: tb/tb_can_pwr_mgr.sv
`timescale 1ns/1ps
module tb_can_pwr_mgr;
  localparam int RECOV_CYC = 16;
  localparam int FILT_LEN  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 1'b0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic cpu_stop = 1'b0, cpu_wait = 1'b0, rx_in = 1'b1;
  logic engine_idle = 1'b1, tx_engine = 1'b1;
  logic tx_out, abort, clk_en, wake_irq, sleep_ack, ready;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  can_pwr_mgr #(.RECOV_CYC(RECOV_CYC), .FILT_LEN(FILT_LEN)) dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .cpu_stop(cpu_stop),
    .cpu_wait(cpu_wait), .rx_in(rx_in), .engine_idle(engine_idle),
    .tx_engine(tx_engine), .tx_out(tx_out), .abort(abort), .clk_en(clk_en),
    .wake_irq(wake_irq), .sleep_ack(sleep_ack), .ready(ready)
  );

  // Bench model: filter outcome for a dominant run of a given length
  function automatic bit filt_wakes(int run);
    return run >= FILT_LEN;
  endfunction

  // Bench model: status byte from its three fields
  function automatic logic [7:0] status_of(bit ack, bit flag, bit rdy);
    return {5'b0, rdy, flag, ack};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
    host_addr = a;
    #0.5;
    d = host_rdata;
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(5 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] v;
    int run;
    void'($urandom(32'h5eed));
    cycles(2);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    rd_reg(2'd0, d); chk("R4 reset ctrl", d, 8'h00);
    rd_reg(2'd1, d); chk("R5 reset status", d, status_of(0, 0, 1));
    chk("R1 reset clk_en", clk_en, 1'b1);

    // R3: pass-through in normal mode
    tx_engine = 1'b0; #0.5; chk("R3 passthrough", tx_out, 1'b0);

    // Random control writes read back (sleep request bit held clear)
    for (int i = 0; i < 8; i++) begin
      v = 8'($urandom) & 8'h1E;
      wr_reg(2'd0, v);
      rd_reg(2'd0, d); chk("R4 ctrl readback", d, v);
    end
    wr_reg(2'd0, 8'h00);

    // R10: sleep held off while engine is busy
    engine_idle = 1'b0;
    wr_reg(2'd0, 8'h01);
    cycles(4);
    chk("R10 ack waits for idle", sleep_ack, 1'b0);
    engine_idle = 1'b1;
    @(negedge clk);
    chk("R10 ack after idle", sleep_ack, 1'b1);
    chk("R3 sleep recessive", tx_out, 1'b1);

    // R7: unfiltered wake
    wr_reg(2'd0, 8'h13);
    rx_in = 1'b0;
    @(negedge clk);
    rx_in = 1'b1;
    chk("R7 woke", sleep_ack, 1'b0);
    chk("R7 ready", ready, 1'b1);
    rd_reg(2'd0, d); chk("R7 sleep bit cleared", d, 8'h12);
    rd_reg(2'd1, d); chk("R7 status", d, status_of(0, 1, 1));
    chk("R9 irq", wake_irq, 1'b1);

    // R9: enable gates irq, W1C clears flag
    wr_reg(2'd0, 8'h02);
    chk("R9 irq gated", wake_irq, 1'b0);
    wr_reg(2'd1, 8'h01);
    rd_reg(2'd1, d); chk("R9 write 0 keeps flag", d, status_of(0, 1, 1));
    wr_reg(2'd1, 8'h02);
    rd_reg(2'd1, d); chk("R9 cleared", d, status_of(0, 0, 1));

    // R11: wake disabled
    wr_reg(2'd0, 8'h01);
    cycles(3);
    chk("R11 asleep", sleep_ack, 1'b1);
    rx_in = 1'b0;
    cycles(5);
    rx_in = 1'b1;
    chk("R11 no wake", sleep_ack, 1'b1);
    rd_reg(2'd1, d); chk("R11 no flag", d, status_of(1, 0, 0));

    // R8: filtered wake, random short runs then exact threshold
    wr_reg(2'd0, 8'h07);
    for (int i = 0; i < 6; i++) begin
      run = $urandom_range(1, FILT_LEN - 1);
      rx_in = 1'b0;
      cycles(run);
      rx_in = 1'b1;
      @(negedge clk);
      chk("R8 short run", sleep_ack, !filt_wakes(run));
    end
    rx_in = 1'b0;
    cycles(FILT_LEN - 1);
    chk("R8 one short", sleep_ack, 1'b1);
    @(negedge clk);
    rx_in = 1'b1;
    chk("R8 full run wakes", sleep_ack, !filt_wakes(FILT_LEN));
    wr_reg(2'd1, 8'h02);

    // R6 + R4: clean power down from sleep
    wr_reg(2'd0, 8'h01);
    cycles(3);
    chk("R6 asleep", sleep_ack, 1'b1);
    cpu_stop = 1'b1;
    #0.5;
    chk("R2 no abort from sleep", abort, 1'b0);
    @(negedge clk);
    chk("R1 stop powers down", clk_en, 1'b0);
    wr_reg(2'd0, 8'h00);
    rd_reg(2'd0, d); chk("R4 read zero in pd", d, 8'h00);
    cpu_stop = 1'b0;
    @(negedge clk);
    chk("R6 back to sleep", sleep_ack, 1'b1);
    chk("R6 not ready", ready, 1'b0);
    rd_reg(2'd0, d); chk("R4 write ignored", d, 8'h01);

    // R1: wait without wait-disable
    wr_reg(2'd0, 8'h00);
    @(negedge clk);
    cpu_wait = 1'b1;
    cycles(3);
    chk("R1 wait alone ignored", clk_en, 1'b1);
    cpu_wait = 1'b0;

    // R2 + R5: unclean power down through wait
    wr_reg(2'd0, 8'h08);
    tx_engine = 1'b0;
    cpu_wait = 1'b1;
    #0.5;
    chk("R2 abort", abort, 1'b1);
    chk("R3 override at request", tx_out, 1'b1);
    @(negedge clk);
    chk("R1 wait+disable pd", clk_en, 1'b0);
    chk("R2 abort ends", abort, 1'b0);
    cpu_wait = 1'b0;
    @(negedge clk);
    chk("R5 recovering", ready, 1'b0);
    chk("R3 recover recessive", tx_out, 1'b1);
    for (int i = 1; i < RECOV_CYC; i++) begin
      @(negedge clk);
      chk("R5 still recovering", ready, 1'b0);
    end
    @(negedge clk);
    chk("R5 ready after delay", ready, 1'b1);
    chk("R3 passthrough again", tx_out, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule